// File: doc/BRIEF.md
# Frame-Based In-Place 256-Point FFT Engine

This block computes a forward 256-point radix-2 transform on complex fixed-point samples, one frame at a time. A one-cycle `start` pulse while the engine is idle is acknowledged in the same cycle. The engine then collects 256 samples from a valid/ready input stream. Each sample is written to a single working memory at the bit-reversed position of its arrival index.

All eight butterfly stages run in place on that memory. One pipelined butterfly unit and a computed twiddle table do the work, and each stage halves its results with rounding, so the full output carries a scale of 1/256. The 256 bins then leave in natural order on a valid/ready output stream, and a one-cycle `done` pulse follows the last one. Loading, computing and unloading never overlap. A new frame can start only after `done`.

Back-pressure rules: an input sample is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_valid` may drop at any time, and only accepted samples count. On the output, `out_valid` stays high with `out_data` unchanged until `out_ready` takes the sample. Neither `in_ready` nor `out_valid` depends on the opposite handshake signal.

Top module: `fft256_inplace`

## Requirements
- R1: `start_ack` is high in exactly the cycle where `start` is high and the engine is idle. A `start` raised while a frame is in progress gets no acknowledge and does not disturb that frame.
- R2: `in_ready` is high only during loading. Exactly 256 samples are accepted per frame, cycles with `in_valid` low are skipped, and `in_ready` is low from the cycle after the 256th accepted sample.
- R3: A sample packs the signed 16-bit imaginary part in bits 31:16 and the signed 16-bit real part in bits 15:0, on both input and output.
- R4: Output bin k (k = 0..255, in that order) is within 4 LSB, per part, of (1/256)·Σ x[n]·e^(−j2πkn/256).
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged in the next cycle.
- R6: `done` is high for exactly one cycle. That cycle is the one right after the 256th output handshake, and it comes only after all 256 outputs.
- R7: An input with real 16384 at index 0 and zero elsewhere gives 64 + 0j in every bin.
- R8: A constant real input of 8000 gives 8000 in bin 0 and zero in every other bin.
- R9: A complex tone of amplitude 12000 at bin 5 gives 12000 + 0j in bin 5 and zero elsewhere.
- R10: During and right after reset, `in_ready`, `out_valid`, `done` and `start_ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame start request (one cycle) |
| start_ack | output | 1 | Acknowledge of an accepted start, same cycle |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Engine is taking input samples |
| in_data | input | 32 | Input sample {imag, real} |
| out_valid | output | 1 | Output bin valid |
| out_ready | input | 1 | Consumer takes the output bin |
| out_data | output | 32 | Output bin {imag, real} |
| done | output | 1 | One-cycle pulse after the last output bin |

## Verification
A fault in the stream handshakes shows up at the ports at once: a stray `in_ready`, a sample counted twice, or a `done` out of place. A wrong butterfly address, twiddle index or load permutation stays hidden inside the memory. It only appears during unload, about 1,300 cycles after the offending sample was taken, as bins that miss their reference. For that reason the bench uses structured frames whose spectra are known in closed form (impulse, real and imaginary DC, a single tone), so a bad pairing or twiddle moves energy to plainly wrong bins. A pseudo-random frame covers mixed signs and all twiddles. Stalls on both streams show whether the counters advance only on real handshakes.

// File: rtl/fft_pkg.sv
package fft_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_ISSUE,
    ST_DRAIN,
    ST_UNLOAD,
    ST_FIN
  } fft_state_e;

  localparam int BFLY_DEPTH = 3;

endpackage

// File: rtl/fft_twiddle_rom.sv
module fft_twiddle_rom #(
  parameter int LOG2N = 8,
  parameter int TW    = 16
) (
  input  logic [LOG2N-2:0]       idx,
  output logic signed [TW-1:0]   w_re,
  output logic signed [TW-1:0]   w_im
);
  localparam int  HALF_N = 1 << (LOG2N - 1);
  localparam real SCALE  = real'((1 << (TW - 1)) - 1);
  localparam real TWO_PI = 6.283185307179586;

  logic signed [TW-1:0] tab_re [HALF_N];
  logic signed [TW-1:0] tab_im [HALF_N];

  // Entry i holds cos(2*pi*i/N) and -sin(2*pi*i/N) in Q1.(TW-1)
  for (genvar i = 0; i < HALF_N; i++) begin : g_tab
    localparam real ANG = TWO_PI * i / (2.0 * HALF_N);
    localparam real CV  = $cos(ANG) * SCALE;
    localparam real SV  = -$sin(ANG) * SCALE;
    localparam int  CI  = $rtoi(CV >= 0.0 ? CV + 0.5 : CV - 0.5);
    localparam int  SI  = $rtoi(SV >= 0.0 ? SV + 0.5 : SV - 0.5);
    assign tab_re[i] = TW'(CI);
    assign tab_im[i] = TW'(SI);
  end

  assign w_re = tab_re[idx];
  assign w_im = tab_im[idx];

endmodule

// File: rtl/fft_butterfly.sv
module fft_butterfly #(
  parameter int DW = 16,
  parameter int TW = 16,
  parameter int AW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 i_valid,
  input  logic signed [DW-1:0] i_ar,
  input  logic signed [DW-1:0] i_ai,
  input  logic signed [DW-1:0] i_br,
  input  logic signed [DW-1:0] i_bi,
  input  logic signed [TW-1:0] i_wr,
  input  logic signed [TW-1:0] i_wi,
  input  logic [AW-1:0]        i_ix0,
  input  logic [AW-1:0]        i_ix1,
  output logic                 o_valid,
  output logic signed [DW-1:0] o_xr,
  output logic signed [DW-1:0] o_xi,
  output logic signed [DW-1:0] o_yr,
  output logic signed [DW-1:0] o_yi,
  output logic [AW-1:0]        o_ix0,
  output logic [AW-1:0]        o_ix1,
  output logic                 o_busy
);
  localparam int PW = DW + TW + 1;
  localparam int SW = DW + TW + 2;
  localparam logic signed [SW-1:0] RND  = SW'(1) <<< (TW - 1);
  localparam logic signed [SW-1:0] MAXP = SW'((1 << (DW - 1)) - 1);
  localparam logic signed [SW-1:0] MINN = -MAXP - SW'(1);

  // divide by 2^TW (twiddle scale and the per-stage halving), round, clamp
  function automatic logic signed [DW-1:0] scale_sat(input logic signed [SW-1:0] x);
    logic signed [SW-1:0] y;
    y = (x + RND) >>> TW;
    if (y > MAXP)      y = MAXP;
    else if (y < MINN) y = MINN;
    return y[DW-1:0];
  endfunction

  logic                 v1, v2;
  logic signed [DW-1:0] ar1, ai1, br1, bi1, ar2, ai2;
  logic signed [TW-1:0] wr1, wi1;
  logic signed [PW-1:0] pr2, pi2;
  logic [AW-1:0]        a1, b1, a2, b2;
  logic signed [SW-1:0] sxr, sxi, syr, syi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      o_valid <= 1'b0;
    end else begin
      v1 <= i_valid;
      v2 <= v1;
      o_valid <= v2;
    end
  end

  always_comb begin
    sxr = (SW'(ar2) <<< (TW - 1)) + SW'(pr2);
    sxi = (SW'(ai2) <<< (TW - 1)) + SW'(pi2);
    syr = (SW'(ar2) <<< (TW - 1)) - SW'(pr2);
    syi = (SW'(ai2) <<< (TW - 1)) - SW'(pi2);
  end

  always_ff @(posedge clk) begin
    ar1 <= i_ar;  ai1 <= i_ai;  br1 <= i_br;  bi1 <= i_bi;
    wr1 <= i_wr;  wi1 <= i_wi;  a1  <= i_ix0; b1  <= i_ix1;
    ar2 <= ar1;   ai2 <= ai1;   a2  <= a1;    b2  <= b1;
    pr2 <= PW'(br1) * PW'(wr1) - PW'(bi1) * PW'(wi1);
    pi2 <= PW'(br1) * PW'(wi1) + PW'(bi1) * PW'(wr1);
    o_xr <= scale_sat(sxr);
    o_xi <= scale_sat(sxi);
    o_yr <= scale_sat(syr);
    o_yi <= scale_sat(syi);
    o_ix0 <= a2;
    o_ix1 <= b2;
  end

  assign o_busy = v1 | v2 | o_valid;

  // R4: every issued butterfly produces a write-back a fixed depth later
  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    i_valid |-> ##3 o_valid);

endmodule

// File: rtl/fft_work_ram.sv
module fft_work_ram #(
  parameter int AW = 8,
  parameter int W  = 32
) (
  input  logic          clk,
  input  logic          we0,
  input  logic [AW-1:0] wa0,
  input  logic [W-1:0]  wd0,
  input  logic          we1,
  input  logic [AW-1:0] wa1,
  input  logic [W-1:0]  wd1,
  input  logic [AW-1:0] ra0,
  output logic [W-1:0]  rd0,
  input  logic [AW-1:0] ra1,
  output logic [W-1:0]  rd1
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we0) mem[wa0] <= wd0;
    if (we1) mem[wa1] <= wd1;
  end

  assign rd0 = mem[ra0];
  assign rd1 = mem[ra1];

endmodule

// File: rtl/fft256_inplace.sv
module fft256_inplace #(
  parameter int LOG2N = 8,
  parameter int DW    = 16,
  parameter int TW    = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            start_ack,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [2*DW-1:0] in_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [2*DW-1:0] out_data,
  output logic            done
);
  import fft_pkg::*;

  localparam int N   = 1 << LOG2N;
  localparam int AW  = LOG2N;
  localparam int CW  = 2 * DW;
  localparam int SGW = (LOG2N > 1) ? $clog2(LOG2N) : 1;

  fft_state_e     st_q;
  logic [AW-1:0]  cnt_q;
  logic [SGW-1:0] stage_q;

  // bit-reversed load address
  logic [AW-1:0] rev_cnt;
  for (genvar i = 0; i < AW; i++) begin : g_rev
    assign rev_cnt[i] = cnt_q[AW-1-i];
  end

  // butterfly pairing for the current stage
  logic [AW-2:0] bidx, jmask, jpart, hpart, tw_idx;
  logic [AW-1:0] idx0, idx1;
  always_comb begin
    bidx   = cnt_q[AW-2:0];
    jmask  = ((AW-1)'(1) << stage_q) - (AW-1)'(1);
    jpart  = bidx & jmask;
    hpart  = bidx & ~jmask;
    idx0   = {hpart, 1'b0} | AW'(jpart);
    idx1   = idx0 | (AW'(1) << stage_q);
    tw_idx = jpart << (SGW'(AW - 1) - stage_q);
  end

  logic [CW-1:0] rd0, rd1;
  logic [AW-1:0] ra0;
  logic signed [TW-1:0] w_re, w_im;

  logic                 bf_ov, bf_busy;
  logic signed [DW-1:0] bf_xr, bf_xi, bf_yr, bf_yi;
  logic [AW-1:0]        bf_i0, bf_i1;

  logic          we0, we1;
  logic [AW-1:0] wa0;
  logic [CW-1:0] wd0;

  assign ra0 = (st_q == ST_UNLOAD) ? cnt_q : idx0;
  assign we0 = ((st_q == ST_LOAD) && in_valid) || bf_ov;
  assign wa0 = (st_q == ST_LOAD) ? rev_cnt : bf_i0;
  assign wd0 = (st_q == ST_LOAD) ? in_data : {bf_xi, bf_xr};
  assign we1 = bf_ov;

  fft_work_ram #(.AW(AW), .W(CW)) u_ram (
    .clk (clk),
    .we0 (we0), .wa0 (wa0),   .wd0 (wd0),
    .we1 (we1), .wa1 (bf_i1), .wd1 ({bf_yi, bf_yr}),
    .ra0 (ra0), .rd0 (rd0),
    .ra1 (idx1), .rd1 (rd1)
  );

  fft_twiddle_rom #(.LOG2N(LOG2N), .TW(TW)) u_rom (
    .idx  (tw_idx),
    .w_re (w_re),
    .w_im (w_im)
  );

  fft_butterfly #(.DW(DW), .TW(TW), .AW(AW)) u_bfly (
    .clk     (clk),
    .rst_n   (rst_n),
    .i_valid (st_q == ST_ISSUE),
    .i_ar    (rd0[DW-1:0]),
    .i_ai    (rd0[CW-1:DW]),
    .i_br    (rd1[DW-1:0]),
    .i_bi    (rd1[CW-1:DW]),
    .i_wr    (w_re),
    .i_wi    (w_im),
    .i_ix0   (idx0),
    .i_ix1   (idx1),
    .o_valid (bf_ov),
    .o_xr    (bf_xr),
    .o_xi    (bf_xi),
    .o_yr    (bf_yr),
    .o_yi    (bf_yi),
    .o_ix0   (bf_i0),
    .o_ix1   (bf_i1),
    .o_busy  (bf_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      stage_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start) begin
          st_q  <= ST_LOAD;
          cnt_q <= '0;
        end
        ST_LOAD: if (in_valid) begin
          cnt_q <= cnt_q + AW'(1);
          if (cnt_q == AW'(N - 1)) begin
            st_q    <= ST_ISSUE;
            stage_q <= '0;
          end
        end
        ST_ISSUE: begin
          if (&cnt_q[AW-2:0]) begin
            st_q  <= ST_DRAIN;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + AW'(1);
          end
        end
        ST_DRAIN: if (!bf_busy) begin
          if (stage_q == SGW'(LOG2N - 1)) begin
            st_q <= ST_UNLOAD;
          end else begin
            st_q    <= ST_ISSUE;
            stage_q <= stage_q + SGW'(1);
          end
        end
        ST_UNLOAD: if (out_ready) begin
          cnt_q <= cnt_q + AW'(1);
          if (cnt_q == AW'(N - 1)) st_q <= ST_FIN;
        end
        ST_FIN: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign start_ack = start && (st_q == ST_IDLE);
  assign in_ready  = (st_q == ST_LOAD);
  assign out_valid = (st_q == ST_UNLOAD);
  assign out_data  = rd0;
  assign done      = (st_q == ST_FIN);

  // R1: an acknowledged start opens the load window next cycle
  p_ack_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_ack |=> in_ready);
  // R2: loading and unloading never overlap
  p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
  // R4: a stage starts only once the previous stage's writes have landed
  p_no_raw_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ISSUE && cnt_q == '0) |-> !bf_busy);
  // R4: the two write-backs of a butterfly target distinct entries
  p_distinct_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bf_ov |-> (bf_i0 != bf_i1));
  // R5: a stalled output holds
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R6: done lasts one cycle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/fft256_inplace_bench.sv
module fft256_inplace_bench;
  localparam int  N   = 256;
  localparam int  TOL = 4;
  localparam real PI2 = 6.283185307179586;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        in_valid = 1'b0;
  logic        out_ready = 1'b0;
  logic [31:0] in_data = '0;
  logic        start_ack, in_ready, out_valid, done;
  logic [31:0] out_data;

  always #5 clk = ~clk;

  fft256_inplace u_fft256_inplace (
    .clk (clk), .rst_n (rst_n),
    .start (start), .start_ack (start_ack),
    .in_valid (in_valid), .in_ready (in_ready), .in_data (in_data),
    .out_valid (out_valid), .out_ready (out_ready), .out_data (out_data),
    .done (done)
  );

  int  checks = 0;
  int  errors = 0;
  int  xr [N];
  int  xi [N];
  real er [N];
  real ei [N];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int rnd(input real v);
    return $rtoi(v >= 0.0 ? v + 0.5 : v - 0.5);
  endfunction

  function automatic int iabs(input int v);
    return v < 0 ? -v : v;
  endfunction

  // direct DFT, forward sign, scaled by 1/N
  task automatic make_ref();
    for (int k = 0; k < N; k++) begin
      real sr, si, a;
      sr = 0.0; si = 0.0;
      for (int n = 0; n < N; n++) begin
        a  = -PI2 * real'((k * n) % N) / real'(N);
        sr += real'(xr[n]) * $cos(a) - real'(xi[n]) * $sin(a);
        si += real'(xr[n]) * $sin(a) + real'(xi[n]) * $cos(a);
      end
      er[k] = sr / real'(N);
      ei[k] = si / real'(N);
    end
  endtask

  task automatic run_frame(input string dtag, input int gap_mod,
                           input int stall_mod, input bit poke_start);
    int sent, recv, cyc, last_x, ar, ai;
    bit seen_done, pv, pr;
    logic [31:0] pd;
    sent = 0; recv = 0; cyc = 0; last_x = -10;
    seen_done = 0; pv = 0; pr = 1; pd = '0;
    make_ref();
    @(negedge clk);
    start = 1'b1;
    #1;
    chk(start_ack === 1'b1, "R1", "ack of idle start", int'(start_ack), 1);
    @(negedge clk);
    start = 1'b0;
    while (!seen_done && cyc < 20000) begin
      in_valid  = (gap_mod == 0) || (cyc % gap_mod != 0);
      in_data   = (sent < N) ? {xi[sent][15:0], xr[sent][15:0]} : 32'hDEAD_BEEF;
      out_ready = (stall_mod == 0) || (cyc % stall_mod != 0);
      start     = poke_start && (sent == 100);
      #1;
      if (start) chk(start_ack === 1'b0, "R1", "no ack while busy", int'(start_ack), 0);
      if (in_ready && sent >= N) chk(1'b0, "R2", "in_ready after full frame", 1, 0);
      if (in_ready && in_valid) sent++;
      if (pv && !pr) begin
        chk(out_valid === 1'b1, "R5", "valid held under stall", int'(out_valid), 1);
        chk(out_data === pd, "R5", "data held under stall", int'(out_data), int'(pd));
      end
      if (out_valid && out_ready) begin
        if (recv < N) begin
          ar = int'($signed(out_data[15:0]));
          ai = int'($signed(out_data[31:16]));
          chk(iabs(ar - rnd(er[recv])) <= TOL, dtag, $sformatf("bin %0d real", recv), ar, rnd(er[recv]));
          chk(iabs(ai - rnd(ei[recv])) <= TOL, dtag, $sformatf("bin %0d imag", recv), ai, rnd(ei[recv]));
        end
        recv++;
        last_x = cyc;
      end
      if (done) begin
        seen_done = 1;
        chk(recv == N, "R6", "outputs before done", recv, N);
        chk(last_x == cyc - 1, "R6", "done one cycle after last output", cyc - last_x, 1);
        chk(sent == N, "R2", "samples accepted", sent, N);
      end
      pv = out_valid; pr = out_ready; pd = out_data;
      cyc++;
      @(negedge clk);
    end
    start = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    if (!seen_done) chk(1'b0, "R6", "watchdog: no done", cyc, 0);
    #1;
    chk(done === 1'b0, "R6", "done single cycle", int'(done), 0);
    chk(in_ready === 1'b0 && out_valid === 1'b0, "R2", "idle after frame",
        int'({in_ready, out_valid}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R10: reset values
    chk(in_ready === 1'b0, "R10", "in_ready in reset", int'(in_ready), 0);
    chk(out_valid === 1'b0, "R10", "out_valid in reset", int'(out_valid), 0);
    chk(done === 1'b0 && start_ack === 1'b0, "R10", "done/ack in reset",
        int'({done, start_ack}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(in_ready === 1'b0 && out_valid === 1'b0 && done === 1'b0, "R10",
        "outputs after reset", int'({in_ready, out_valid, done}), 0);

    // R7: impulse
    for (int n = 0; n < N; n++) begin xr[n] = 0; xi[n] = 0; end
    xr[0] = 16384;
    run_frame("R7", 0, 0, 1'b0);

    // R8: real DC, input gaps, start poked during load (R1)
    for (int n = 0; n < N; n++) begin xr[n] = 8000; xi[n] = 0; end
    run_frame("R8", 5, 0, 1'b1);

    // R3: imaginary-only DC under output stalls
    for (int n = 0; n < N; n++) begin xr[n] = 0; xi[n] = 6000; end
    run_frame("R3", 0, 3, 1'b0);

    // R9: complex tone at bin 5
    for (int n = 0; n < N; n++) begin
      xr[n] = rnd(12000.0 * $cos(PI2 * real'((5 * n) % N) / real'(N)));
      xi[n] = rnd(12000.0 * $sin(PI2 * real'((5 * n) % N) / real'(N)));
    end
    run_frame("R9", 0, 0, 1'b0);

    // R4: pseudo-random frame, stalls on both sides
    begin
      int seed;
      seed = 12345;
      for (int n = 0; n < N; n++) begin
        seed  = (seed * 1103515245 + 12345) & 32'h7fff_ffff;
        xr[n] = (seed % 30001) - 15000;
        seed  = (seed * 1103515245 + 12345) & 32'h7fff_ffff;
        xi[n] = (seed % 30001) - 15000;
      end
    end
    run_frame("R4", 4, 2, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule